// File: doc/BRIEF.md
# Second-Level Bus Arbiter Proxy

This block sits between several downstream bus-master slots and a primary bus arbiter. Each slot has its own active-low request and grant pair. Toward the primary arbiter, the block presents the whole group through one active-low request and grant pair, so the primary arbiter sees a single agent.

The block picks one requesting slot in round-robin order. It drives that slot's grant only while the upstream grant is held. It follows FRAME# and IRDY# to detect when the granted master has started its transaction.

A grant always ends in a clock with no downstream grant asserted. A grant ends when:
- its master starts a transaction,
- its master drops its request first, or
- the upstream grant goes away.

Because of this, pipelined arbitration can never leave two masters each believing it owns the bus. A new grant may be issued while an earlier transaction is still on the bus.

Top module: `slot_arb_proxy`

## Requirements
- R1: `up_req_n` is low one clock after any `slot_req_n` bit was sampled low. It is high one clock after all bits were sampled high.
- R2: At most one bit of `slot_gnt_n` is low at any time.
- R3: A low `slot_gnt_n` bit never changes to a different low bit on a clock edge. Between the removal of one grant and the assertion of the next, there is at least one clock with every `slot_gnt_n` bit high.
- R4: A grant is issued only if `up_gnt_n` was sampled low on that edge. If `up_gnt_n` is sampled high while a grant is held, `slot_gnt_n` is all high one clock later.
- R5: The search order starts at the slot after the most recently granted one and wraps from slot NSLOT-1 to slot 0. After reset the last-granted slot is 0, so slot 1 has first priority.
- R6: The bus is idle when FRAME# and IRDY# are both high. If a grant is held and `frame_n` is sampled low in the clock right after a clock in which the bus was idle, the grant is removed on that edge.
- R7: If the granted slot's `slot_req_n` bit is sampled high before that slot has started a transaction, the grant is removed one clock later.
- R8: A grant is issued even while the bus is busy. It is held for any number of clocks while its request and the upstream grant stay low and no start occurs.
- R9: If no slot is requesting, no `slot_gnt_n` bit is driven low on the next clock.
- R10: A synchronous low `rst_n` drives every `slot_gnt_n` bit high and `up_req_n` high, and it resets the last-granted slot to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_req_n | input | NSLOT | Downstream requests, active low, one per slot |
| slot_gnt_n | output | NSLOT | Downstream grants, active low, one per slot |
| up_req_n | output | 1 | Combined request to the primary arbiter, active low |
| up_gnt_n | input | 1 | Grant from the primary arbiter, active low |
| frame_n | input | 1 | Bus FRAME#, active low |
| irdy_n | input | 1 | Bus IRDY#, active low |

## Verification
The grant vector, the last-granted pointer and the bus-idle flag are the only state, and every one of them reaches the ports within one or two clocks:
- A wrong grant vector shows on `slot_gnt_n` in the same clock.
- A wrong pointer shows at the next grant, as the wrong slot winning the round-robin race.
- A wrong idle flag shows as a grant that is dropped one clock early or is kept after FRAME# falls.

The stimulus chains grants across wrap-around, upstream loss, withdrawal and pipelined issue during a busy bus, so each of these faults moves an observed grant pattern.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;

    // Reason a held grant is released on the current edge.
    typedef enum logic [1:0] {
        REL_NONE     = 2'd0,
        REL_UPLOST   = 2'd1,
        REL_START    = 2'd2,
        REL_WITHDRAW = 2'd3
    } rel_e;

endpackage

// File: rtl/slot_arb_rr_pick.sv
// Round-robin search: first requesting slot after 'last', wrapping around.
module slot_arb_rr_pick #(
    parameter int unsigned NSLOT = 8
) (
    input  logic [NSLOT-1:0]         req,
    input  logic [$clog2(NSLOT)-1:0] last,
    output logic                     found,
    output logic [$clog2(NSLOT)-1:0] pick
);
    localparam int unsigned IW = $clog2(NSLOT);

    logic [IW-1:0] idx;

    always_comb begin
        found = 1'b0;
        pick  = last;
        idx   = last;
        for (int unsigned off = 1; off <= NSLOT; off++) begin
            idx = IW'((int'(last) + int'(off)) % int'(NSLOT));
            if (!found && req[idx]) begin
                found = 1'b1;
                pick  = idx;
            end
        end
    end
endmodule

// File: rtl/slot_arb_bus_watch.sv
// Tracks bus idleness and flags a transaction start: FRAME# falling
// in the clock after a clock with FRAME# and IRDY# both high.
module slot_arb_bus_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    output logic start
);
    logic idle_d, idle_q;

    always_comb begin
        idle_d = frame_n & irdy_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idle_q <= 1'b1;
        else        idle_q <= idle_d;
    end

    assign start = idle_q & ~frame_n;
endmodule

// File: rtl/slot_arb_proxy.sv
module slot_arb_proxy
    import slot_arb_pkg::*;
#(
    parameter int unsigned NSLOT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] slot_req_n,
    output logic [NSLOT-1:0] slot_gnt_n,
    output logic             up_req_n,
    input  logic             up_gnt_n,
    input  logic             frame_n,
    input  logic             irdy_n
);
    localparam int unsigned IW = $clog2(NSLOT);

    typedef struct packed {
        logic [NSLOT-1:0] gnt;     // one-hot active-high grant, zero when none
        logic [IW-1:0]    last;    // most recently granted slot
        logic             up_req;  // active-high upstream request
    } st_t;

    st_t s_d, s_q;

    logic [NSLOT-1:0] req;
    logic             up_ok;
    logic             held;
    logic             found;
    logic [IW-1:0]    pick;
    logic             start;
    rel_e             why;

    assign req   = ~slot_req_n;
    assign up_ok = ~up_gnt_n;
    assign held  = |s_q.gnt;

    slot_arb_rr_pick #(.NSLOT(NSLOT)) u_pick (
        .req   (req),
        .last  (s_q.last),
        .found (found),
        .pick  (pick)
    );

    slot_arb_bus_watch u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_n (frame_n),
        .irdy_n  (irdy_n),
        .start   (start)
    );

    always_comb begin
        s_d        = s_q;
        why        = REL_NONE;
        s_d.up_req = |req;
        if (held) begin
            // Every release passes through an all-idle grant clock.
            if (!up_ok)                     why = REL_UPLOST;
            else if (start)                 why = REL_START;
            else if (!(|(req & s_q.gnt)))   why = REL_WITHDRAW;
            if (why != REL_NONE) s_d.gnt = '0;
        end else if (up_ok && found) begin
            s_d.gnt  = NSLOT'(1) << pick;
            s_d.last = pick;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.gnt    <= '0;
            s_q.last   <= '0;
            s_q.up_req <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign slot_gnt_n = ~s_q.gnt;
    assign up_req_n   = ~s_q.up_req;
endmodule

// File: rtl/slot_arb_proxy_chk.sv
module slot_arb_proxy_chk #(
    parameter int unsigned NSLOT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NSLOT-1:0] slot_req_n,
    input logic [NSLOT-1:0] slot_gnt_n,
    input logic             up_req_n,
    input logic             up_gnt_n,
    input logic             frame_n,
    input logic             irdy_n
);
    logic [NSLOT-1:0] g;
    logic [NSLOT-1:0] r;
    assign g = ~slot_gnt_n;
    assign r = ~slot_req_n;

    p_upreq_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (up_req_n == $past(&slot_req_n)));

    p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(g));

    p_dead_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (g != '0) |=> (g == '0 || g == $past(g)));

    p_upstream_needed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((g != '0) && up_gnt_n) |=> (g == '0));

    p_start_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((g != '0) && !frame_n && $past(frame_n & irdy_n)) |=> (g == '0));

    p_withdraw_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((g & ~r) != '0) |=> (g == '0));

    p_no_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (&slot_req_n) |=> (g == '0));
endmodule

bind slot_arb_proxy slot_arb_proxy_chk #(.NSLOT(NSLOT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_req_n (slot_req_n),
    .slot_gnt_n (slot_gnt_n),
    .up_req_n   (up_req_n),
    .up_gnt_n   (up_gnt_n),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n)
);

// File: tb/slot_arb_proxy_tb.sv
`timescale 1ns/1ps
module slot_arb_proxy_tb;
    localparam int unsigned NSLOT = 8;
    localparam int NV = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NSLOT-1:0] slot_req_n;
    logic [NSLOT-1:0] slot_gnt_n;
    logic             up_req_n;
    logic             up_gnt_n;
    logic             frame_n;
    logic             irdy_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    slot_arb_proxy #(.NSLOT(NSLOT)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_req_n (slot_req_n),
        .slot_gnt_n (slot_gnt_n),
        .up_req_n   (up_req_n),
        .up_gnt_n   (up_gnt_n),
        .frame_n    (frame_n),
        .irdy_n     (irdy_n)
    );

    // {req_n[8], up_gnt_n, frame_n, irdy_n, expected gnt_n[8], expected up_req_n}
    localparam logic [19:0] VEC [NV] = '{
        {8'hFF, 3'b111, 8'hFF, 1'b1},
        {8'hFB, 3'b111, 8'hFF, 1'b0},
        {8'hFB, 3'b011, 8'hFB, 1'b0},
        {8'hFB, 3'b001, 8'hFF, 1'b0},
        {8'hFF, 3'b001, 8'hFF, 1'b1},
        {8'hDE, 3'b010, 8'hDF, 1'b0},
        {8'hDE, 3'b011, 8'hDF, 1'b0},
        {8'hDE, 3'b001, 8'hFF, 1'b0},
        {8'hFE, 3'b001, 8'hFE, 1'b0},
        {8'hFF, 3'b000, 8'hFF, 1'b1},
        {8'h7F, 3'b011, 8'h7F, 1'b0},
        {8'h7F, 3'b111, 8'hFF, 1'b0},
        {8'h7F, 3'b111, 8'hFF, 1'b0},
        {8'h7E, 3'b011, 8'hFE, 1'b0},
        {8'h7E, 3'b001, 8'hFF, 1'b0},
        {8'h7F, 3'b001, 8'h7F, 1'b0}
    };

    function automatic string vtag(input int i);
        case (i)
            0:       return "R9";
            1:       return "R1";
            2:       return "R4";
            3:       return "R6";
            4:       return "R1";
            5:       return "R8";
            6:       return "R8";
            7:       return "R6";
            8:       return "R3";
            9:       return "R7";
            10:      return "R5";
            11:      return "R4";
            12:      return "R4";
            13:      return "R5";
            14:      return "R6";
            default: return "R3";
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; slot_req_n = '1; up_gnt_n = 1'b1; frame_n = 1'b1; irdy_n = 1'b1;
        repeat (3) tick();
        chk("R10", "reset gnt_n", 32'(slot_gnt_n), 32'hFF);
        chk("R10", "reset up_req_n", 32'(up_req_n), 32'h1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            slot_req_n = VEC[i][19:12];
            up_gnt_n   = VEC[i][11];
            frame_n    = VEC[i][10];
            irdy_n     = VEC[i][9];
            tick();
            chk(vtag(i), $sformatf("vec %0d gnt_n", i), 32'(slot_gnt_n), 32'(VEC[i][8:1]));
            chk("R1", $sformatf("vec %0d up_req_n", i), 32'(up_req_n), 32'(VEC[i][0]));
        end

        // R10: reset while slot 7 holds a grant
        rst_n = 1'b0;
        tick();
        chk("R10", "mid-grant reset gnt_n", 32'(slot_gnt_n), 32'hFF);
        chk("R10", "mid-grant reset up_req_n", 32'(up_req_n), 32'h1);

        // R5: pointer back at slot 0, so slot 1 wins with everyone requesting
        rst_n = 1'b1; slot_req_n = '0; up_gnt_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1;
        tick();
        chk("R5", "post-reset first winner", 32'(slot_gnt_n), 32'hFD);

        // R8: no timeout while waiting for FRAME#
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R8", $sformatf("hold %0d", k), 32'(slot_gnt_n), 32'hFD);
        end

        // R6 then R3: start drops grant, next slot follows after one idle clock
        frame_n = 1'b0;
        tick();
        chk("R6", "start release", 32'(slot_gnt_n), 32'hFF);
        tick();
        chk("R3", "next after dead clock", 32'(slot_gnt_n), 32'hFB);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule